// File: doc/BRIEF.md
# Byte-Array Program Controller

This block puts a small non-volatile byte array behind a simple synchronous bus (address, write data, write strobe, read strobe, registered read data). The array occupies the lower half of the address space, and one control/status byte sits at a fixed address in the upper half. The controller models slow cell programming with a cycle counter. While the counter runs, a busy flag is raised and the array is locked out.

There are two ways to write. In byte mode, a single bus write to the array programs that one location. In row mode, bus writes go at full speed into an eight-byte latch that covers one aligned row: the upper address bits are fixed and the low three bits pick the byte. Setting the start bit then programs the whole row in one busy period. Reads from an idle, awake array return the stored byte one clock after the read strobe.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After reset the control byte reads 00h, busy is low and no mode bit is set.
- R2: The control byte layout is: bit0 write enable, bit1 busy (read-only), bit2 row mode, bit3 row start (set-only), bit6 standby. Bits 7, 5 and 4 always read 0 and ignore writes. Writing bit3 without bit0 and bit2 both set in the same write does not start anything.
- R3: An array write while write enable is 0 leaves the array unchanged and does not raise busy.
- R4: An enabled byte-mode array write raises busy for exactly PROG_CYCLES cycles, starting the cycle after the write. The new byte can be read once busy falls.
- R5: While busy, array writes are discarded, array reads return 00h, and the programming already under way completes in its original time.
- R6: While busy, writes to the control byte are ignored.
- R7: In row mode with start clear, array writes fill the latch without raising busy or changing the array. A write to a row other than the one captured by the first latched write is ignored.
- R8: A control write with bits 0, 2 and 3 set (bit6 clear) programs the latched row. The control byte reads with start set during the busy period, and both start and row mode clear when it ends.
- R9: Row bytes that were not latched before start read FFh after the row is programmed.
- R10: Clearing row mode before start discards the latch and leaves the array unchanged.
- R11: With standby set, array reads return 00h and array writes are ignored without raising busy.
- R12: A read of an idle array or of the control byte presents its data on bus_rdata one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW+1 | Byte address; top bit clear selects the array |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid one cycle after bus_rd |

## Verification
The hardest case to reach is an access that lands inside a busy window while a programming job is still running. The bench checks that the job finishes on its original schedule while the intruding array write, array read and control write are all dropped. To get there, it issues a byte program and then, on the following back-to-back bus cycles, fires a conflicting write, a read and a control write. It then polls the control byte one cycle at a time and counts how many busy reads remain. That count must equal the program time minus the cycles already spent. The row-abandon case is reached by latching a byte and clearing row mode. A new row holding a single byte is then programmed, and the byte that was abandoned must come back as the fill value.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int CB_WEN   = 0;
  localparam int CB_BUSY  = 1;
  localparam int CB_ROW   = 2;
  localparam int CB_START = 3;
  localparam int CB_STBY  = 6;

  localparam logic [7:0] ROW_FILL = 8'hFF;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_MEM  = 2'd1,
    RSEL_CTRL = 2'd2
  } rsel_e;
endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int CYCLES = 20,
  localparam int CW = $clog2(CYCLES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = busy && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/nvm_row_buf.sv
module nvm_row_buf #(
  parameter int AW = 6,
  localparam int TW = AW - 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  output logic          tag_vld,
  output logic [TW-1:0] tag,
  input  logic [2:0]    rd_idx,
  output logic          rd_vld,
  output logic [7:0]    rd_data
);
  logic [7:0] slot [8];
  logic [7:0] vld;

  assign rd_vld  = vld[rd_idx];
  assign rd_data = slot[rd_idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld     <= '0;
      tag_vld <= 1'b0;
      tag     <= '0;
    end else if (wr) begin
      vld[waddr[2:0]] <= 1'b1;
      tag_vld         <= 1'b1;
      tag             <= waddr[AW-1:3];
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && waddr[2:0] == 3'(g)) slot[g] <= wdata;
    end
  end
endmodule

// File: rtl/nvm_mem.sv
module nvm_mem #(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_pkg::*;
#(
  parameter int          AW          = 6,
  parameter int          PROG_CYCLES = 20,
  parameter logic [AW:0] CTRL_ADDR   = {1'b1, {AW{1'b0}}}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata
);
  localparam int TW = AW - 3;
  localparam int CW = $clog2(PROG_CYCLES) + 1;

  logic wen_q, rowen_q, start_q, standby_q;
  logic busy, last;
  logic [CW-1:0] cnt;

  logic is_arr, is_ctrl, acc_ok, arr_wr_ok, ctrl_wr;
  logic lat_wr, byte_go, row_go, go, lat_clr;
  logic tag_vld, rd_vld;
  logic [TW-1:0] tag;
  logic [7:0] lat_byte;

  logic          job_row;
  logic [AW-1:0] job_addr;
  logic [7:0]    job_data;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata, mem_q, ctrl_byte, ctrl_q;
  rsel_e         rsel_q;

  assign is_arr  = !bus_addr[AW];
  assign is_ctrl = (bus_addr == CTRL_ADDR);
  assign acc_ok  = !busy && !standby_q;

  assign arr_wr_ok = bus_wr && is_arr && acc_ok && wen_q;
  assign lat_wr    = arr_wr_ok && rowen_q &&
                     (!tag_vld || tag == bus_addr[AW-1:3]);
  assign byte_go   = arr_wr_ok && !rowen_q;
  assign ctrl_wr   = bus_wr && is_ctrl && !busy;
  assign row_go    = ctrl_wr && bus_wdata[CB_START] && bus_wdata[CB_ROW] &&
                     bus_wdata[CB_WEN] && !bus_wdata[CB_STBY];
  assign go        = byte_go || row_go;
  assign lat_clr   = (ctrl_wr && !bus_wdata[CB_ROW]) || (last && job_row);

  nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .cnt(cnt), .last(last)
  );

  nvm_row_buf #(.AW(AW)) u_row (
    .clk(clk), .rst(rst), .clr(lat_clr), .wr(lat_wr),
    .waddr(bus_addr[AW-1:0]), .wdata(bus_wdata),
    .tag_vld(tag_vld), .tag(tag),
    .rd_idx(cnt[2:0]), .rd_vld(rd_vld), .rd_data(lat_byte)
  );

  // control byte and job capture
  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q     <= 1'b0;
      rowen_q   <= 1'b0;
      start_q   <= 1'b0;
      standby_q <= 1'b0;
      job_row   <= 1'b0;
      job_addr  <= '0;
      job_data  <= '0;
    end else begin
      if (ctrl_wr) begin
        wen_q     <= bus_wdata[CB_WEN];
        rowen_q   <= bus_wdata[CB_ROW];
        standby_q <= bus_wdata[CB_STBY];
        if (row_go) start_q <= 1'b1;
      end
      if (last && job_row) begin
        start_q <= 1'b0;
        rowen_q <= 1'b0;
      end
      if (go) begin
        job_row  <= row_go;
        job_addr <= bus_addr[AW-1:0];
        job_data <= bus_wdata;
      end
    end
  end

  // array write port: byte job in first busy cycle, row job over first eight
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = job_addr;
    mem_wdata = job_data;
    if (busy) begin
      if (job_row) begin
        mem_we    = (cnt < CW'(8));
        mem_waddr = {tag, cnt[2:0]};
        mem_wdata = rd_vld ? lat_byte : ROW_FILL;
      end else begin
        mem_we = (cnt == '0);
      end
    end
  end

  nvm_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(bus_addr[AW-1:0]), .rdata(mem_q)
  );

  assign ctrl_byte = {1'b0, standby_q, 2'b00, start_q, rowen_q, busy, wen_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RSEL_NONE;
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_byte;
      if (bus_rd && is_arr && acc_ok) rsel_q <= RSEL_MEM;
      else if (bus_rd && is_ctrl)     rsel_q <= RSEL_CTRL;
      else                            rsel_q <= RSEL_NONE;
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_MEM:  bus_rdata = mem_q;
      RSEL_CTRL: bus_rdata = ctrl_q;
      default:   bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/nvm_wr_ctrl_sva.sv
module nvm_wr_ctrl_sva (
  input logic clk,
  input logic rst,
  input logic bus_wr,
  input logic is_arr,
  input logic wen_q,
  input logic rowen_q,
  input logic start_q,
  input logic standby_q,
  input logic busy,
  input logic last,
  input logic job_row,
  input logic mem_we
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy && !wen_q && !rowen_q && !start_q && !standby_q));

  assert_disabled_no_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_wr && is_arr && !wen_q) |=> !busy);

  assert_byte_sets_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_wr && is_arr && wen_q && !rowen_q && !standby_q) |=> busy);

  assert_array_write_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable({wen_q, standby_q}));

  assert_latch_no_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_wr && is_arr && wen_q && rowen_q) |=> !busy);

  assert_row_end_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (last && job_row) |=> (!start_q && !rowen_q));

  assert_standby_no_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && standby_q && bus_wr && is_arr) |=> !busy);
endmodule

bind nvm_wr_ctrl nvm_wr_ctrl_sva u_sva (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .is_arr(is_arr),
  .wen_q(wen_q), .rowen_q(rowen_q), .start_q(start_q), .standby_q(standby_q),
  .busy(busy), .last(last), .job_row(job_row), .mem_we(mem_we)
);

// File: tb/nvm_wr_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_wr_ctrl_tb;
  localparam int AW = 6;
  localparam int P  = 20;
  localparam logic [AW:0] CTRL = 7'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nvm_wr_ctrl #(.AW(AW), .PROG_CYCLES(P), .CTRL_ADDR(CTRL)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every bus task enters and leaves at a falling edge
  task automatic wr(input logic [AW:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic busy_reads(output int n);
    logic [7:0] v;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      rd(CTRL, v);
      if (!v[1]) break;
      n++;
    end
  endtask

  task automatic prog_byte(input logic [AW:0] a, input logic [7:0] d);
    int n;
    wr(a, d);
    busy_reads(n);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(CTRL, v); check("R1 reset control", v, 8'h00);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] v;
    wr(CTRL, 8'hB2); rd(CTRL, v); check("R2 busy/reserved/bit7 not writable", v, 8'h00);
    wr(CTRL, 8'h41); rd(CTRL, v); check("R2 standby and enable bits", v, 8'h41);
    wr(CTRL, 8'h09); rd(CTRL, v); check("R2 start without row mode", v, 8'h01);
  endtask

  task automatic t_byte();
    logic [7:0] v;
    int n;
    wr(CTRL, 8'h01);
    wr(7'd5, 8'hA5);
    busy_reads(n); check("R4 busy length", n, P);
    rd(7'd5, v); check("R4 R12 read back next cycle", v, 8'hA5);
    prog_byte(7'd7, 8'h70);
    prog_byte(7'd8, 8'h11);
    prog_byte(7'd18, 8'h44);
    prog_byte(7'd40, 8'h33);
    rd(7'd40, v); check("R4 second byte", v, 8'h33);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(CTRL, 8'h00);
    wr(7'd5, 8'h5A);
    rd(CTRL, v); check("R3 no busy when disabled", v, 8'h00);
    rd(7'd5, v); check("R3 array unchanged", v, 8'hA5);
  endtask

  task automatic t_busy_lock();
    logic [7:0] v;
    int n;
    wr(CTRL, 8'h01);
    wr(7'd6, 8'h66);
    wr(7'd7, 8'h99);
    rd(7'd6, v); check("R5 read during busy", v, 8'h00);
    wr(CTRL, 8'h40);
    busy_reads(n); check("R5 job completes on time", n, P - 3);
    rd(CTRL, v); check("R6 control write ignored", v, 8'h01);
    rd(7'd6, v); check("R5 programmed byte", v, 8'h66);
    rd(7'd7, v); check("R5 write during busy dropped", v, 8'h70);
  endtask

  task automatic t_row();
    logic [7:0] v;
    int n;
    wr(CTRL, 8'h05);
    wr(7'd16, 8'hA0); wr(7'd17, 8'hA1); wr(7'd18, 8'hA2); wr(7'd19, 8'hA3);
    wr(7'd40, 8'hEE);
    rd(CTRL, v); check("R7 latch writes no busy", v, 8'h05);
    rd(7'd18, v); check("R7 array untouched before start", v, 8'h44);
    wr(CTRL, 8'h0D);
    rd(CTRL, v); check("R8 start reads set while busy", v, 8'h0F);
    busy_reads(n); check("R8 row busy length", n, P - 1);
    rd(CTRL, v); check("R8 start and row cleared", v, 8'h01);
    for (int i = 0; i < 4; i++) begin
      rd(7'(16 + i), v); check("R8 row byte", v, 8'hA0 + i);
    end
    for (int i = 4; i < 8; i++) begin
      rd(7'(16 + i), v); check("R9 unlatched byte fill", v, 8'hFF);
    end
    rd(7'd40, v); check("R7 other row ignored", v, 8'h33);
  endtask

  task automatic t_abandon();
    logic [7:0] v;
    int n;
    wr(CTRL, 8'h05);
    wr(7'd8, 8'h77);
    wr(CTRL, 8'h01);
    rd(7'd8, v); check("R10 array unchanged after abandon", v, 8'h11);
    rd(CTRL, v); check("R10 no busy after abandon", v, 8'h01);
    wr(CTRL, 8'h05);
    wr(7'd9, 8'h99);
    wr(CTRL, 8'h0D);
    busy_reads(n);
    rd(7'd8, v); check("R10 abandoned byte not reused", v, 8'hFF);
    rd(7'd9, v); check("R10 new row byte", v, 8'h99);
  endtask

  task automatic t_standby();
    logic [7:0] v;
    wr(CTRL, 8'h41);
    rd(7'd9, v); check("R11 read in standby", v, 8'h00);
    wr(7'd9, 8'h12);
    rd(CTRL, v); check("R11 no busy in standby", v, 8'h41);
    wr(CTRL, 8'h01);
    rd(7'd9, v); check("R11 write in standby ignored", v, 8'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_byte();
    t_disabled();
    t_busy_lock();
    t_row();
    t_abandon();
    t_standby();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule